// File: doc/BRIEF.md
# Tagged Write Data Checker

This block watches a write channel on which up to sixteen write transactions are in flight at once, each known by a 4-bit tag. When a request is accepted, the block stores a 128-bit vector of expected bytes for that tag. It then follows the 8-bit data beats sent for that tag and compares each beat with the next stored byte. It reports a one-cycle pulse whenever a beat carries the wrong byte.

Beats for different tags may interleave freely. A tag may be told to retry at any point from acceptance up to the cycle after its last beat. A retry rewinds that tag to its first byte and keeps its stored data. There is no limit on how many times a tag may retry. A completion pulse marks each transfer that survives its retry window. Traffic that makes no sense for the current state of a tag raises a coded protocol error.

The checker is a passive monitor. It drives no ready signal and never back-pressures the channel. Every input cycle with a valid flag counts as a transfer. All outputs are registered.

Top module: `tagged_wr_checker`

## Requirements
- R1: A request is accepted in a cycle where `req_vld_i` and `req_ack_i` are both high. That cycle stores `req_vec_i` under tag `req_tag_i`, marks the tag active and sets its beat index to 0.
- R2: A beat is a cycle with `beat_vld_i` high, belonging to tag `beat_tag_i`. Beat number k of a tag is compared with byte k of its stored vector, counted from the top: byte k is bits [127-8k : 120-8k]. On a difference, `mis_o` pulses in the next cycle with `mis_tag_o` set to the tag and `mis_idx_o` set to k.
- R3: Beats whose bytes match raise no pulse. The beat index of each tag advances independently when beats of different tags interleave.
- R4: A beat with `beat_last_i` high ends the transfer. Unless a retry for that tag occurs in the next cycle, `done_o` pulses two cycles after the last beat, with `done_tag_o` set to the tag. The tag then becomes inactive.
- R5: A retry is a cycle with `retry_i` high for tag `retry_tag_i`. On an active tag, it sets the beat index back to 0 and keeps the stored vector. Any number of retries is accepted.
- R6: A retry in the cycle right after a last beat cancels that completion and rewinds the tag to beat 0.
- R7: When a beat and a retry for the same tag occur in the same cycle, the beat is still compared and the index returns to 0.
- R8: A beat for an inactive tag gives `err_o` one cycle later with `err_kind_o` = 1 and `err_tag_o` = the tag.
- R9: A retry for an inactive tag gives `err_o` with `err_kind_o` = 2 and `err_tag_o` = the tag. If both this and a beat error occur in the same cycle, the beat error is reported.
- R10: A beat for a tag in the cycle right after its last beat gives `err_kind_o` = 3 and is not compared.
- R11: A beat at index 15 without `beat_last_i` and without a same-tag retry gives `err_kind_o` = 4. It is compared, and the index stays at 15.
- R12: A synchronous active-high `rst_i` clears all outputs and makes every tag inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_vld_i | input | 1 | Write request present |
| req_ack_i | input | 1 | Write request acknowledged |
| req_tag_i | input | 4 | Tag given at acknowledgment |
| req_vec_i | input | 128 | Expected bytes, first beat in the top byte |
| beat_vld_i | input | 1 | Data beat present |
| beat_tag_i | input | 4 | Tag of the beat |
| beat_data_i | input | 8 | Beat byte |
| beat_last_i | input | 1 | Beat is the final one of its transfer |
| retry_i | input | 1 | Retry request |
| retry_tag_i | input | 4 | Tag being retried |
| mis_o | output | 1 | Data mismatch pulse |
| mis_tag_o | output | 4 | Tag of the mismatching beat |
| mis_idx_o | output | 4 | Beat index of the mismatching beat |
| done_o | output | 1 | Completion pulse |
| done_tag_o | output | 4 | Completed tag |
| err_o | output | 1 | Protocol error pulse |
| err_kind_o | output | 3 | Error code (1..4, see R8–R11) |
| err_tag_o | output | 4 | Tag of the error |

## Verification
The hardest situations to reach are the one-cycle window after a last beat, where a retry must cancel completion, and the same cycle holding both a beat and a retry for one tag. Both depend on exact cycle alignment between two independent input streams. The stimulus table gives each clock its own row, so a retry can be placed exactly in the tail cycle or on top of a beat. Index overrun needs sixteen beats without a last flag, so a directed loop produces it. The same loop style runs twenty back-to-back retries, and afterwards a deliberately wrong first byte proves the index still rewinds.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

  typedef enum logic [2:0] {
    WDC_OK         = 3'd0,
    WDC_IDLE_BEAT  = 3'd1,
    WDC_IDLE_RETRY = 3'd2,
    WDC_LATE_BEAT  = 3'd3,
    WDC_OVERRUN    = 3'd4
  } wdc_err_e;

endpackage

// File: rtl/wdc_slot.sv
// Per-tag tracking state: active flag, beat index, expected vector and the
// one-cycle window after the last beat during which a retry may still land.
module wdc_slot #(
  parameter int BEAT_W    = 8,
  parameter int MAX_BEATS = 16,
  localparam int VEC_W    = BEAT_W * MAX_BEATS,
  localparam int IDX_W    = $clog2(MAX_BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              acc_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              beat_i,
  input  logic              last_i,
  input  logic              retry_i,
  output logic              active_o,
  output logic              tail_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BEAT_W-1:0] lane_o,
  output logic              done_o
);

  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_BEATS - 1);

  logic             active_q;
  logic             tail_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_q <= 1'b0;
      tail_q   <= 1'b0;
      idx_q    <= '0;
    end else if (acc_i) begin
      active_q <= 1'b1;
      tail_q   <= 1'b0;
      idx_q    <= '0;
    end else if (active_q) begin
      if (tail_q) begin
        tail_q <= 1'b0;
        if (retry_i) idx_q <= '0;
        else         active_q <= 1'b0;
      end else if (retry_i) begin
        idx_q <= '0;
      end else if (beat_i) begin
        if (last_i)              tail_q <= 1'b1;
        else if (idx_q != IDX_TOP) idx_q <= idx_q + 1'b1;
      end
    end
  end

  // expected data is a datapath register: loaded on acceptance only
  always_ff @(posedge clk_i) begin
    if (acc_i) vec_q <= vec_i;
  end

  assign active_o = active_q;
  assign tail_o   = tail_q;
  assign idx_o    = idx_q;
  assign lane_o   = vec_q[(MAX_BEATS - 1 - int'(idx_q)) * BEAT_W +: BEAT_W];
  assign done_o   = active_q && tail_q && !retry_i;

endmodule

// File: rtl/wdc_beat_judge.sv
// Classifies the current beat and retry against the state of their tags.
module wdc_beat_judge
  import wdc_pkg::*;
#(
  parameter int BEAT_W    = 8,
  parameter int MAX_BEATS = 16,
  localparam int IDX_W    = $clog2(MAX_BEATS)
) (
  input  logic              beat_vld_i,
  input  logic              last_i,
  input  logic              act_i,
  input  logic              tail_i,
  input  logic              rtr_same_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BEAT_W-1:0] lane_i,
  input  logic [BEAT_W-1:0] data_i,
  input  logic              retry_vld_i,
  input  logic              retry_act_i,
  output logic              mis_o,
  output wdc_err_e          err_o
);

  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_BEATS - 1);

  logic live;
  assign live  = beat_vld_i && act_i && !tail_i;
  assign mis_o = live && (data_i != lane_i);

  always_comb begin
    err_o = WDC_OK;
    if (beat_vld_i && !act_i)
      err_o = WDC_IDLE_BEAT;
    else if (beat_vld_i && tail_i)
      err_o = WDC_LATE_BEAT;
    else if (live && !last_i && !rtr_same_i && (idx_i == IDX_TOP))
      err_o = WDC_OVERRUN;
    else if (retry_vld_i && !retry_act_i)
      err_o = WDC_IDLE_RETRY;
  end

endmodule

// File: rtl/wdc_report.sv
// Output registers for the three event streams.
module wdc_report
  import wdc_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             mis_i,
  input  logic [TAG_W-1:0] mis_tag_i,
  input  logic [IDX_W-1:0] mis_idx_i,
  input  logic             done_i,
  input  logic [TAG_W-1:0] done_tag_i,
  input  wdc_err_e         err_i,
  input  logic [TAG_W-1:0] err_tag_i,
  output logic             mis_o,
  output logic [TAG_W-1:0] mis_tag_o,
  output logic [IDX_W-1:0] mis_idx_o,
  output logic             done_o,
  output logic [TAG_W-1:0] done_tag_o,
  output logic             err_o,
  output logic [2:0]       err_kind_o,
  output logic [TAG_W-1:0] err_tag_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mis_o      <= 1'b0;
      mis_tag_o  <= '0;
      mis_idx_o  <= '0;
      done_o     <= 1'b0;
      done_tag_o <= '0;
      err_o      <= 1'b0;
      err_kind_o <= 3'd0;
      err_tag_o  <= '0;
    end else begin
      mis_o      <= mis_i;
      mis_tag_o  <= mis_i ? mis_tag_i : '0;
      mis_idx_o  <= mis_i ? mis_idx_i : '0;
      done_o     <= done_i;
      done_tag_o <= done_i ? done_tag_i : '0;
      err_o      <= (err_i != WDC_OK);
      err_kind_o <= err_i;
      err_tag_o  <= (err_i != WDC_OK) ? err_tag_i : '0;
    end
  end

endmodule

// File: rtl/tagged_wr_checker.sv
module tagged_wr_checker
  import wdc_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int BEAT_W    = 8,
  parameter int MAX_BEATS = 16,
  localparam int VEC_W    = BEAT_W * MAX_BEATS,
  localparam int IDX_W    = $clog2(MAX_BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_vld_i,
  input  logic              req_ack_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  input  logic              beat_vld_i,
  input  logic [TAG_W-1:0]  beat_tag_i,
  input  logic [BEAT_W-1:0] beat_data_i,
  input  logic              beat_last_i,
  input  logic              retry_i,
  input  logic [TAG_W-1:0]  retry_tag_i,
  output logic              mis_o,
  output logic [TAG_W-1:0]  mis_tag_o,
  output logic [IDX_W-1:0]  mis_idx_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  done_tag_o,
  output logic              err_o,
  output logic [2:0]        err_kind_o,
  output logic [TAG_W-1:0]  err_tag_o
);

  localparam int NTAGS = 1 << TAG_W;

  logic              accept;
  logic [NTAGS-1:0]  act_v;
  logic [NTAGS-1:0]  tail_v;
  logic [NTAGS-1:0]  done_v;
  logic [IDX_W-1:0]  idx_v  [NTAGS];
  logic [BEAT_W-1:0] lane_v [NTAGS];

  assign accept = req_vld_i && req_ack_i;

  for (genvar t = 0; t < NTAGS; t++) begin : g_slot
    wdc_slot #(
      .BEAT_W    (BEAT_W),
      .MAX_BEATS (MAX_BEATS)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .acc_i    (accept && (req_tag_i == TAG_W'(t))),
      .vec_i    (req_vec_i),
      .beat_i   (beat_vld_i && (beat_tag_i == TAG_W'(t))),
      .last_i   (beat_last_i),
      .retry_i  (retry_i && (retry_tag_i == TAG_W'(t))),
      .active_o (act_v[t]),
      .tail_o   (tail_v[t]),
      .idx_o    (idx_v[t]),
      .lane_o   (lane_v[t]),
      .done_o   (done_v[t])
    );
  end

  // at most one tag can sit in its tail cycle, since last beats are serial
  logic             done_any;
  logic [TAG_W-1:0] done_tag;
  always_comb begin
    done_any = 1'b0;
    done_tag = '0;
    for (int t = 0; t < NTAGS; t++) begin
      if (done_v[t]) begin
        done_any = 1'b1;
        done_tag = TAG_W'(t);
      end
    end
  end

  logic     mis_ev;
  wdc_err_e err_ev;
  logic     rtr_same;
  assign rtr_same = retry_i && (retry_tag_i == beat_tag_i);

  wdc_beat_judge #(
    .BEAT_W    (BEAT_W),
    .MAX_BEATS (MAX_BEATS)
  ) u_judge (
    .beat_vld_i  (beat_vld_i),
    .last_i      (beat_last_i),
    .act_i       (act_v[beat_tag_i]),
    .tail_i      (tail_v[beat_tag_i]),
    .rtr_same_i  (rtr_same),
    .idx_i       (idx_v[beat_tag_i]),
    .lane_i      (lane_v[beat_tag_i]),
    .data_i      (beat_data_i),
    .retry_vld_i (retry_i),
    .retry_act_i (act_v[retry_tag_i]),
    .mis_o       (mis_ev),
    .err_o       (err_ev)
  );

  logic [TAG_W-1:0] err_tag;
  assign err_tag = (err_ev == WDC_IDLE_RETRY) ? retry_tag_i : beat_tag_i;

  wdc_report #(
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_report (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .mis_i      (mis_ev),
    .mis_tag_i  (beat_tag_i),
    .mis_idx_i  (idx_v[beat_tag_i]),
    .done_i     (done_any),
    .done_tag_i (done_tag),
    .err_i      (err_ev),
    .err_tag_i  (err_tag),
    .mis_o      (mis_o),
    .mis_tag_o  (mis_tag_o),
    .mis_idx_o  (mis_idx_o),
    .done_o     (done_o),
    .done_tag_o (done_tag_o),
    .err_o      (err_o),
    .err_kind_o (err_kind_o),
    .err_tag_o  (err_tag_o)
  );

endmodule

// File: rtl/wdc_sva.sv
module wdc_sva #(
  parameter int TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             beat_vld_i,
  input logic [TAG_W-1:0] beat_tag_i,
  input logic             beat_last_i,
  input logic             retry_i,
  input logic [TAG_W-1:0] retry_tag_i,
  input logic             mis_o,
  input logic [TAG_W-1:0] mis_tag_o,
  input logic             done_o,
  input logic [TAG_W-1:0] done_tag_o,
  input logic             err_o,
  input logic [2:0]       err_kind_o,
  input logic [TAG_W-1:0] err_tag_o
);

  // R2
  mis_needs_beat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    mis_o |-> ($past(beat_vld_i) && (mis_tag_o == $past(beat_tag_i))));

  // R4
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> ($past(beat_vld_i && beat_last_i, 2) && ($past(beat_tag_i, 2) == done_tag_o)));

  // R6
  no_done_on_retry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !($past(retry_i) && ($past(retry_tag_i) == done_tag_o)));

  // R9
  idle_retry_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_o && (err_kind_o == 3'd2)) |-> ($past(retry_i) && ($past(retry_tag_i) == err_tag_o)));

  // R10
  late_beat_no_mis_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_o && (err_kind_o == 3'd3)) |-> !mis_o);

  // R12
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!mis_o && !done_o && !err_o));

endmodule

bind tagged_wr_checker wdc_sva #(.TAG_W(TAG_W)) u_sva (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .beat_vld_i  (beat_vld_i),
  .beat_tag_i  (beat_tag_i),
  .beat_last_i (beat_last_i),
  .retry_i     (retry_i),
  .retry_tag_i (retry_tag_i),
  .mis_o       (mis_o),
  .mis_tag_o   (mis_tag_o),
  .done_o      (done_o),
  .done_tag_o  (done_tag_o),
  .err_o       (err_o),
  .err_kind_o  (err_kind_o),
  .err_tag_o   (err_tag_o)
);

// File: tb/tb_tagged_wr_checker.sv
`timescale 1ns/1ps
module tb_tagged_wr_checker;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_vld, req_ack;
  logic [3:0]   req_tag;
  logic [127:0] req_vec;
  logic         beat_vld;
  logic [3:0]   beat_tag;
  logic [7:0]   beat_data;
  logic         beat_last;
  logic         retry;
  logic [3:0]   retry_tag;
  logic         mis, done, err;
  logic [3:0]   mis_tag, mis_idx, done_tag, err_tag;
  logic [2:0]   err_kind;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tagged_wr_checker dut (
    .clk_i(clk), .rst_i(rst),
    .req_vld_i(req_vld), .req_ack_i(req_ack), .req_tag_i(req_tag), .req_vec_i(req_vec),
    .beat_vld_i(beat_vld), .beat_tag_i(beat_tag), .beat_data_i(beat_data),
    .beat_last_i(beat_last), .retry_i(retry), .retry_tag_i(retry_tag),
    .mis_o(mis), .mis_tag_o(mis_tag), .mis_idx_o(mis_idx),
    .done_o(done), .done_tag_o(done_tag),
    .err_o(err), .err_kind_o(err_kind), .err_tag_o(err_tag)
  );

  typedef struct packed {
    logic       acc;  logic [3:0] atag;
    logic       rtr;  logic [3:0] rtag;
    logic       bv;   logic [3:0] btag; logic [3:0] bk; logic bad; logic blast;
    logic       emis; logic [3:0] emtag; logic [3:0] emidx;
    logic       edone; logic [3:0] edtag;
    logic [2:0] ekind; logic [3:0] eetag;
  } row_t;

  localparam int NROWS = 23;
  // fields: acc atag rtr rtag | bv btag bk bad blast | emis emtag emidx | edone edtag | ekind eetag
  localparam row_t TAB [NROWS] = '{
    '{1,3, 0,0, 0,0,0,0,0, 0,0,0, 0,0, 0,0},  // R1 accept tag 3
    '{1,9, 0,0, 0,0,0,0,0, 0,0,0, 0,0, 0,0},  // R1 accept tag 9
    '{0,0, 0,0, 1,3,0,0,0, 0,0,0, 0,0, 0,0},  // R3 good beat
    '{0,0, 0,0, 1,9,0,0,0, 0,0,0, 0,0, 0,0},  // R3 interleaved good beat
    '{0,0, 0,0, 1,3,1,1,0, 1,3,1, 0,0, 0,0},  // R2 wrong byte at index 1
    '{0,0, 0,0, 1,9,1,0,1, 0,0,0, 0,0, 0,0},  // R4 last beat of tag 9
    '{0,0, 0,0, 0,0,0,0,0, 0,0,0, 1,9, 0,0},  // R4 completion of tag 9
    '{0,0, 1,3, 0,0,0,0,0, 0,0,0, 0,0, 0,0},  // R5 retry mid-transfer
    '{0,0, 0,0, 1,3,0,0,0, 0,0,0, 0,0, 0,0},  // R5 restarted at byte 0
    '{0,0, 0,0, 1,3,1,0,1, 0,0,0, 0,0, 0,0},  // last beat of tag 3
    '{0,0, 1,3, 0,0,0,0,0, 0,0,0, 0,0, 0,0},  // R6 retry in tail cycle
    '{0,0, 0,0, 1,3,0,0,0, 0,0,0, 0,0, 0,0},  // R6 no completion, byte 0 again
    '{0,0, 1,3, 1,3,1,0,0, 0,0,0, 0,0, 0,0},  // R7 beat plus retry
    '{0,0, 0,0, 1,3,0,1,0, 1,3,0, 0,0, 0,0},  // R7 index back to 0
    '{0,0, 1,3, 1,3,1,1,0, 1,3,1, 0,0, 0,0},  // R7 beat still compared
    '{0,0, 0,0, 1,3,0,0,1, 0,0,0, 0,0, 0,0},  // last beat after rewind
    '{0,0, 0,0, 0,0,0,0,0, 0,0,0, 1,3, 0,0},  // R4 completion of tag 3
    '{0,0, 0,0, 1,3,0,0,0, 0,0,0, 0,0, 1,3},  // R8 beat on inactive tag
    '{0,0, 1,5, 0,0,0,0,0, 0,0,0, 0,0, 2,5},  // R9 retry on inactive tag
    '{1,9, 0,0, 0,0,0,0,0, 0,0,0, 0,0, 0,0},  // R1 reuse of tag 9
    '{0,0, 0,0, 1,9,0,0,1, 0,0,0, 0,0, 0,0},  // single-beat transfer
    '{0,0, 0,0, 1,9,1,0,0, 0,0,0, 1,9, 3,9},  // R10 beat in tail cycle
    '{0,0, 0,0, 0,0,0,0,0, 0,0,0, 0,0, 0,0}
  };

  function automatic logic [7:0] good_byte(input logic [3:0] tag, input logic [3:0] k);
    return {tag, k} ^ 8'hA5;
  endfunction

  function automatic logic [127:0] build_vec(input logic [3:0] tag);
    logic [127:0] v = '0;
    for (int k = 0; k < 16; k++) v[127 - 8*k -: 8] = good_byte(tag, 4'(k));
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    req_vld = 0; req_ack = 0; req_tag = 0; req_vec = '0;
    beat_vld = 0; beat_tag = 0; beat_data = 0; beat_last = 0;
    retry = 0; retry_tag = 0;
  endtask

  task automatic do_accept(input logic [3:0] t);
    req_vld = 1; req_ack = 1; req_tag = t; req_vec = build_vec(t);
  endtask

  task automatic do_beat(input logic [3:0] t, input logic [3:0] k, input bit bad, input bit last);
    beat_vld = 1; beat_tag = t; beat_last = last;
    beat_data = good_byte(t, k) ^ (bad ? 8'h01 : 8'h00);
  endtask

  // inputs are set just after a falling edge; this waits one full cycle
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string req);
    check(!mis && !done && !err, req, "quiet", {mis, done, err}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!mis && !done && !err, "R12", "outputs after reset", {mis, done, err}, 0);
    rst = 0;

    for (int r = 0; r < NROWS; r++) begin
      row_t w = TAB[r];
      clear_in();
      if (w.acc) do_accept(w.atag);
      if (w.bv)  do_beat(w.btag, w.bk, w.bad, w.blast);
      if (w.rtr) begin retry = 1; retry_tag = w.rtag; end
      tick();
      check(mis == w.emis && (!w.emis || (mis_tag == w.emtag && mis_idx == w.emidx)),
            "R2", $sformatf("row %0d mismatch", r), {mis, mis_tag, mis_idx}, {w.emis, w.emtag, w.emidx});
      check(done == w.edone && (!w.edone || done_tag == w.edtag),
            "R4", $sformatf("row %0d completion", r), {done, done_tag}, {w.edone, w.edtag});
      check(err == (w.ekind != 0) && err_kind == w.ekind && err_tag == w.eetag,
            "R8", $sformatf("row %0d error", r), {err_kind, err_tag}, {w.ekind, w.eetag});
    end

    // R11 overrun: sixteen beats, none marked last
    clear_in(); do_accept(4'd1); tick();
    for (int k = 0; k < 16; k++) begin
      clear_in(); do_beat(4'd1, 4'(k), 0, 0); tick();
      if (k < 15) expect_quiet("R11");
      else check(err && err_kind == 3'd4 && err_tag == 4'd1 && !mis, "R11", "overrun",
                 {err, err_kind, err_tag}, {1'b1, 3'd4, 4'd1});
    end
    clear_in(); do_beat(4'd1, 4'd15, 0, 1); tick();
    expect_quiet("R11");  // index held at 15, byte 15 matches
    clear_in(); tick();
    check(done && done_tag == 4'd1, "R4", "completion after overrun", {done, done_tag}, {1'b1, 4'd1});

    // R5 many retries in a row
    clear_in(); do_accept(4'd7); tick();
    for (int n = 0; n < 20; n++) begin
      clear_in(); do_beat(4'd7, 4'd0, 0, 0); tick();
      clear_in(); do_beat(4'd7, 4'd1, 0, 0); tick();
      clear_in(); retry = 1; retry_tag = 4'd7; tick();
      expect_quiet("R5");
    end
    clear_in(); do_beat(4'd7, 4'd0, 1, 0); tick();
    check(mis && mis_tag == 4'd7 && mis_idx == 4'd0, "R5", "rewind after retries",
          {mis, mis_tag, mis_idx}, {1'b1, 4'd7, 4'd0});

    // R12 reset in flight clears active tags
    clear_in(); do_accept(4'd2); tick();
    rst = 1; clear_in(); tick();
    check(!mis && !done && !err, "R12", "outputs during reset", {mis, done, err}, 0);
    rst = 0; do_beat(4'd2, 4'd0, 0, 0); tick();
    check(err && err_kind == 3'd1 && err_tag == 4'd2, "R12", "tag inactive after reset",
          {err, err_kind, err_tag}, {1'b1, 3'd1, 4'd2});
    clear_in(); tick();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule